// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked state machine that performs one single-word read or write at a time on an asynchronous static RAM. On the client side it takes a one-cycle request with a direction bit, an address and write data. It answers with a one-cycle completion pulse and, for reads, a registered data word. On the memory side it drives an active-low and an active-high chip select, an active-low output enable, an active-low write strobe, the address, and write data with its own drive enable. It samples the read data returned by the memory.

Every nanosecond limit of the memory is a parameter. At elaboration each limit becomes a whole number of clock periods: the limit divided by the period, rounded up, with zero left as zero. Writes are always ended by the write strobe. A per-request mode input keeps output enable low during a write. In that mode the drive enable waits for the memory's turn-off delay after the strobe falls. After every read the controller also waits out the output turn-off delay before it drives the data bus again.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, both chip selects, output enable and the write strobe are inactive (`mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1), `mem_dout_en`=0 and `done`=0.
- R2: A read asserts both chip selects and `mem_oe_n`=0 and holds the address, with `mem_we_n`=1, for exactly RD cycles. RD is the largest of the cycle counts of address access, chip-select access and output-enable access, and at least 1. The word on `mem_din` at the final edge of that window appears on `rdata`.
- R3: A write drives `mem_we_n`=0 only while both chip selects are active, with a stable address. The strobe stays low for the pulse minimum, which is the largest of the cycle counts of strobe width, chip-select-to-end, address-to-end and write cycle, and at least 1. It also stays low until data has been driven for SD cycles, where SD is the data setup count and at least 1. Chip selects, address and data are held for at least one cycle after the strobe rises, or for more if the hold limits need it.
- R4: `mem_dout_en` is 1 only during write states. It is never 1 while `mem_oe_n`=0, except while the strobe is low in output-enable-hold mode.
- R5: When `oe_hold_mode`=1 at acceptance, `mem_oe_n` stays 0 while the strobe is low. `mem_dout_en` then rises no earlier than the strobe-turn-off cycle count after the strobe falls, so the strobe stays low for at least that count plus SD cycles. Output enable is released at the edge where the strobe rises.
- R6: After a read releases output enable, `mem_dout_en` does not rise until TURN cycles have passed. TURN is the larger of the output-enable and chip-select turn-off counts. A write accepted in the cycle right after a read therefore keeps its strobe low for at least TURN-1+SD cycles.
- R7: `done` is a one-cycle pulse. For a read it rises in the cycle when `rdata` is updated. For a write it rises in the cycle after the hold ends, when the chip selects go inactive.
- R8: `req` is acted on only in the idle state. A request presented during an access gives no `done`, no bus activity and no change to the access in progress.
- R9: Each cycle count is the nanosecond limit divided by `CLK_PERIOD_NS`, rounded up. A zero limit contributes no cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled in idle |
| we | input | 1 | 1 = write, 0 = read |
| oe_hold_mode | input | 1 | Keep output enable low through a write |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | Data returned by the memory |

## Verification
Writes are issued in three settings, and each gives a different strobe-low length. A write from a quiet idle shows the data-setup bound alone. A write in output-enable-hold mode adds the strobe-turn-off gap. A normal write accepted in the cycle right after a read must absorb the remaining read turnaround. Reads are run both after idle gaps and back to back, so that a stale or mis-addressed sample is caught. The output-enable window is measured against the access bound. One write carries an overlapping read request, which must leave no trace.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_ACCESS = 2'd1,
        ST_WR_PULSE  = 2'd2,
        ST_WR_HOLD   = 2'd3
    } acc_state_e;

    // Whole clock periods covering a nanosecond limit; zero stays zero.
    function automatic int ns_to_cycles(input int lim_ns, input int period_ns);
        if (lim_ns <= 0) return 0;
        return (lim_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    // Saturating up-counter: counts edges since the last clear.
    always_comb begin
        count_d = count_q;
        if (clear)
            count_d = '0;
        else if (count_q != {CNT_W{1'b1}})
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (capture) rdata_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_AA_NS       = 20,  // address to valid data
    parameter int T_ACE_NS      = 20,  // chip select to valid data
    parameter int T_DOE_NS      = 8,   // output enable to valid data
    parameter int T_HZOE_NS     = 8,   // output off after output enable rises
    parameter int T_HZCE_NS     = 10,  // output off after chip select release
    parameter int T_HZWE_NS     = 10,  // output off after strobe falls
    parameter int T_WC_NS       = 20,  // full write cycle
    parameter int T_SCE_NS      = 18,  // chip select to write end
    parameter int T_AW_NS       = 15,  // address setup to write end
    parameter int T_HA_NS       = 0,   // address hold after write end
    parameter int T_PWE_NS      = 13,  // strobe low width
    parameter int T_SD_NS       = 10,  // data setup to write end
    parameter int T_HD_NS       = 0    // data hold after write end
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              oe_hold_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    // ---------------- cycle counts derived from the limits ----------------
    localparam int C_AA   = ns_to_cycles(T_AA_NS,   CLK_PERIOD_NS);
    localparam int C_ACE  = ns_to_cycles(T_ACE_NS,  CLK_PERIOD_NS);
    localparam int C_DOE  = ns_to_cycles(T_DOE_NS,  CLK_PERIOD_NS);
    localparam int C_HZOE = ns_to_cycles(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int C_HZCE = ns_to_cycles(T_HZCE_NS, CLK_PERIOD_NS);
    localparam int C_HZWE = ns_to_cycles(T_HZWE_NS, CLK_PERIOD_NS);
    localparam int C_WC   = ns_to_cycles(T_WC_NS,   CLK_PERIOD_NS);
    localparam int C_SCE  = ns_to_cycles(T_SCE_NS,  CLK_PERIOD_NS);
    localparam int C_AW   = ns_to_cycles(T_AW_NS,   CLK_PERIOD_NS);
    localparam int C_HA   = ns_to_cycles(T_HA_NS,   CLK_PERIOD_NS);
    localparam int C_PWE  = ns_to_cycles(T_PWE_NS,  CLK_PERIOD_NS);
    localparam int C_SD   = ns_to_cycles(T_SD_NS,   CLK_PERIOD_NS);
    localparam int C_HD   = ns_to_cycles(T_HD_NS,   CLK_PERIOD_NS);

    localparam int RD_CYC    = max_of(1, max_of(C_AA, max_of(C_ACE, C_DOE)));
    localparam int PULSE_CYC = max_of(1, max_of(max_of(C_PWE, C_SCE), max_of(C_AW, C_WC)));
    localparam int SD_CYC    = max_of(1, C_SD);
    localparam int HOLD_CYC  = max_of(1, max_of(C_HD, C_HA));
    localparam int GAP_WE    = C_HZWE;
    localparam int TURN_CYC  = max_of(C_HZOE, C_HZCE);

    localparam int CNT_MAX = RD_CYC + PULSE_CYC + GAP_WE + SD_CYC + HOLD_CYC + TURN_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
    localparam int TURN_W  = $clog2(TURN_CYC + 1) + 1;

    localparam logic [CNT_W-1:0]  RD_LAST    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0]  PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0]  SD_LAST    = CNT_W'(SD_CYC - 1);
    localparam logic [CNT_W-1:0]  HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0]  GAP_LAST   = CNT_W'((GAP_WE == 0) ? 0 : GAP_WE - 1);
    localparam logic [TURN_W-1:0] TURN_LOAD  = TURN_W'(TURN_CYC);

    // ---------------- registered controller state ----------------
    typedef struct packed {
        acc_state_e        state;
        logic              ce_act;
        logic              oe_act;
        logic              we_act;
        logic              dout_en;
        logic              done;
        logic              oe_hold;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [TURN_W-1:0] turn;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:   ST_IDLE,
        ce_act:  1'b0,
        oe_act:  1'b0,
        we_act:  1'b0,
        dout_en: 1'b0,
        done:    1'b0,
        oe_hold: 1'b0,
        addr:    '0,
        wdata:   '0,
        turn:    '0
    };

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0] phase_cnt;   // edges since entering the current state
    logic [CNT_W-1:0] age_cnt;     // edges since write data started driving
    logic             phase_clear;
    logic             age_clear;
    logic             capture;

    // Restart the phase count on every state change.
    assign phase_clear = (ctl_d.state != ctl_q.state);
    // Data age counts only while the data bus is driven.
    assign age_clear   = !ctl_q.dout_en;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_phase_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_clear),
        .count (phase_cnt)
    );

    sram_cycle_timer #(.CNT_W(CNT_W)) u_age_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (age_clear),
        .count (age_cnt)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_rd_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_din),
        .rdata   (rdata)
    );

    // ---------------- turnaround window after a read ----------------
    logic turn_clear;
    generate
        if (TURN_CYC == 0) begin : g_no_turn
            assign turn_clear = 1'b1;
        end else begin : g_turn
            // Drive may start at the edge where the window runs out.
            assign turn_clear = (ctl_q.turn <= TURN_W'(1));
        end
    endgenerate

    logic gap_ok;
    logic pulse_ok;
    logic setup_ok;

    assign gap_ok   = !ctl_q.oe_hold || (phase_cnt >= GAP_LAST);
    assign pulse_ok = (phase_cnt >= PULSE_LAST);
    assign setup_ok = ctl_q.dout_en && (age_cnt >= SD_LAST);

    // ---------------- next-state logic ----------------
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        capture    = 1'b0;

        if (ctl_q.turn != '0)
            ctl_d.turn = ctl_q.turn - 1'b1;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.addr    = addr;
                    ctl_d.wdata   = wdata;
                    ctl_d.oe_hold = we && oe_hold_mode;
                    ctl_d.ce_act  = 1'b1;
                    if (we) begin
                        ctl_d.state   = ST_WR_PULSE;
                        ctl_d.we_act  = 1'b1;
                        ctl_d.oe_act  = oe_hold_mode;
                        ctl_d.dout_en = turn_clear && (!oe_hold_mode || (GAP_WE == 0));
                    end else begin
                        ctl_d.state   = ST_RD_ACCESS;
                        ctl_d.oe_act  = 1'b1;
                    end
                end
            end

            ST_RD_ACCESS: begin
                if (phase_cnt == RD_LAST) begin
                    capture      = 1'b1;
                    ctl_d.done   = 1'b1;
                    ctl_d.ce_act = 1'b0;
                    ctl_d.oe_act = 1'b0;
                    ctl_d.turn   = TURN_LOAD;
                    ctl_d.state  = ST_IDLE;
                end
            end

            ST_WR_PULSE: begin
                if (!ctl_q.dout_en && gap_ok && turn_clear)
                    ctl_d.dout_en = 1'b1;
                if (setup_ok && pulse_ok) begin
                    // Strobe rise ends the write; output enable drops with it
                    // so the memory never turns its output on during the hold.
                    ctl_d.we_act = 1'b0;
                    ctl_d.oe_act = 1'b0;
                    ctl_d.state  = ST_WR_HOLD;
                end
            end

            ST_WR_HOLD: begin
                if (phase_cnt == HOLD_LAST) begin
                    ctl_d.ce_act  = 1'b0;
                    ctl_d.dout_en = 1'b0;
                    ctl_d.oe_hold = 1'b0;
                    ctl_d.done    = 1'b1;
                    ctl_d.state   = ST_IDLE;
                end
            end

            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    // ---------------- pin mapping ----------------
    assign mem_ce_n    = !ctl_q.ce_act;
    assign mem_ce      = ctl_q.ce_act;
    assign mem_oe_n    = !ctl_q.oe_act;
    assign mem_we_n    = !ctl_q.we_act;
    assign mem_addr    = ctl_q.addr;
    assign mem_dout    = ctl_q.wdata;
    assign mem_dout_en = ctl_q.dout_en;
    assign done        = ctl_q.done;

    // ---------------- assertions ----------------
    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |-> (mem_ce_n && !mem_ce && mem_we_n && !mem_dout_en)); // R1

    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_RD_ACCESS) |-> (!mem_oe_n && mem_we_n && !mem_ce_n && mem_ce)); // R2

    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce)); // R3

    AST_ADDR_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R3

    AST_STROBE_LOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($past(age_cnt) >= SD_LAST && $past(mem_dout_en))); // R3

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (ctl_q.state == ST_WR_PULSE || ctl_q.state == ST_WR_HOLD)); // R4

    AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en && !mem_oe_n) |-> (!mem_we_n && ctl_q.oe_hold)); // R5

    AST_TURN_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (ctl_q.turn == '0)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != ST_IDLE && req) |=> $stable(mem_addr)); // R8

endmodule

// File: tb/test_sram_access_ctrl.sv
module test_sram_access_ctrl;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int PERIOD = 20;

    // Bench-side timing set, deliberately multi-cycle at 50 MHz.
    localparam int NS_AA = 50, NS_ACE = 45, NS_DOE = 8;
    localparam int NS_HZOE = 8, NS_HZCE = 30, NS_HZWE = 25;
    localparam int NS_WC = 20, NS_SCE = 18, NS_AW = 15, NS_HA = 0;
    localparam int NS_PWE = 13, NS_SD = 30, NS_HD = 0;

    function automatic int cyc(input int ns);        // R9
        return (ns == 0) ? 0 : (ns + PERIOD - 1) / PERIOD;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD    = mx(1, mx(cyc(NS_AA), mx(cyc(NS_ACE), cyc(NS_DOE))));
    localparam int EXP_PULSE = mx(1, mx(mx(cyc(NS_PWE), cyc(NS_SCE)), mx(cyc(NS_AW), cyc(NS_WC))));
    localparam int EXP_SD    = mx(1, cyc(NS_SD));
    localparam int EXP_GAPWE = cyc(NS_HZWE);
    localparam int EXP_TURN  = mx(cyc(NS_HZOE), cyc(NS_HZCE));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0, oe_hold_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic done;
    logic mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout, mem_din;

    always #10 clk = ~clk;

    sram_access_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PERIOD),
        .T_AA_NS(NS_AA), .T_ACE_NS(NS_ACE), .T_DOE_NS(NS_DOE),
        .T_HZOE_NS(NS_HZOE), .T_HZCE_NS(NS_HZCE), .T_HZWE_NS(NS_HZWE),
        .T_WC_NS(NS_WC), .T_SCE_NS(NS_SCE), .T_AW_NS(NS_AW), .T_HA_NS(NS_HA),
        .T_PWE_NS(NS_PWE), .T_SD_NS(NS_SD), .T_HD_NS(NS_HD)
    ) i_sram_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .oe_hold_mode(oe_hold_mode),
        .addr(addr), .wdata(wdata), .rdata(rdata), .done(done),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem    [64];
    logic [DW-1:0] shadow [64];
    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 16'hC000 | DW'(i);
            shadow[i] = 16'hC000 | DW'(i);
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_ce) begin
            check(mem_dout_en, "R4 data driven at write end", int'(mem_dout_en), 1);
            mem[mem_addr] = mem_dout;
        end
    end

    assign mem_din = (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) ? mem[mem_addr] : '0;

    // ---------------- scoreboard ----------------
    typedef struct {
        logic          is_wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            len;
    } exp_t;
    exp_t exp_q[$];
    logic cur_mode = 1'b0;

    int we_run = 0, we_last = 0, oe_run = 0, oe_last = 0, rel = 100;
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_den = 1'b0, prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            // strobe and output-enable window measurement
            if (!mem_we_n) we_run++;
            if (!mem_oe_n) oe_run++;
            if (mem_we_n && !prev_we_n) begin
                we_last = we_run;
                we_run  = 0;
                check(!mem_ce_n && mem_ce, "R3 select held after strobe rise", int'(mem_ce), 1);
            end
            if (mem_oe_n && !prev_oe_n) begin
                oe_last = oe_run;
                oe_run  = 0;
                if (mem_we_n && prev_we_n) rel = 0;   // a read just released the bus
            end else if (rel < 100) begin
                rel++;
            end
            if (mem_dout_en && !prev_den)
                check(rel >= EXP_TURN, "R6 turnaround before drive", rel, EXP_TURN);
            if (mem_dout_en && !mem_oe_n && !cur_mode)
                check(1'b0, "R4 drive while output enabled", 1, 0);
            if (!mem_we_n && cur_mode)
                check(!mem_oe_n, "R5 output enable held in write", int'(mem_oe_n), 0);
            if (done && prev_done)
                check(1'b0, "R7 done longer than one cycle", 1, 0);

            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 done with no accepted request", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_wr) begin
                        check(we_last == e.len, "R3 strobe low cycles", we_last, e.len);
                        check(mem[e.a] == e.d, "R3 memory word written", int'(mem[e.a]), int'(e.d));
                    end else begin
                        check(rdata == e.d, "R2 read data", int'(rdata), int'(e.d));
                        check(oe_last == e.len, "R2 output enable cycles", oe_last, e.len);
                    end
                end
            end
            prev_we_n = mem_we_n;
            prev_oe_n = mem_oe_n;
            prev_den  = mem_dout_en;
            prev_done = done;
        end
    end

    // ---------------- driver ----------------
    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic m, input int len);
        exp_t e;
        if (w) shadow[a] = d;
        e.is_wr = w; e.a = a; e.d = w ? d : shadow[a]; e.len = len;
        exp_q.push_back(e);
        cur_mode = w && m;
        req = 1'b1; we = w; addr = a; wdata = d; oe_hold_mode = m;
        @(negedge clk);
        req = 1'b0;
        wait_done();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int n = 0; n < 20000; n++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int wr_idle, wr_hold, wr_after_rd;
        wr_idle     = mx(EXP_PULSE, EXP_SD);
        wr_hold     = mx(EXP_PULSE, EXP_GAPWE + EXP_SD);
        wr_after_rd = mx(EXP_PULSE, mx(EXP_TURN - 1, 0) + EXP_SD);

        repeat (4) @(negedge clk);
        check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n, "R1 selects inactive in reset",
              {mem_ce_n, mem_ce, mem_oe_n, mem_we_n}, 4'b1011);
        rst_n = 1'b1;
        idle(2);
        check(mem_ce_n == 1'b1, "R1 mem_ce_n idle", int'(mem_ce_n), 1);
        check(mem_ce == 1'b0, "R1 mem_ce idle", int'(mem_ce), 0);
        check(mem_oe_n == 1'b1, "R1 mem_oe_n idle", int'(mem_oe_n), 1);
        check(mem_we_n == 1'b1, "R1 mem_we_n idle", int'(mem_we_n), 1);
        check(!mem_dout_en && !done, "R1 no drive no done", {mem_dout_en, done}, 0);

        // R3 R9: write from quiet idle, normal mode
        issue(1'b1, 6'h05, 16'h1234, 1'b0, wr_idle);
        idle(3);
        // R2: read back
        issue(1'b0, 6'h05, 16'h0, 1'b0, EXP_RD);
        // R6: normal write in the cycle right after a read
        issue(1'b1, 6'h06, 16'hBEEF, 1'b0, wr_after_rd);
        idle(3);
        // R2: back-to-back reads
        issue(1'b0, 6'h06, 16'h0, 1'b0, EXP_RD);
        issue(1'b0, 6'h05, 16'h0, 1'b0, EXP_RD);
        issue(1'b0, 6'h3F, 16'h0, 1'b0, EXP_RD);
        idle(3);
        // R5: output-enable-hold write
        issue(1'b1, 6'h07, 16'h55AA, 1'b1, wr_hold);
        idle(3);
        issue(1'b0, 6'h07, 16'h0, 1'b0, EXP_RD);
        // R5 R6: hold-mode write right after a read
        issue(1'b1, 6'h08, 16'h0F1E, 1'b1, mx(wr_hold, wr_after_rd));
        cur_mode = 1'b0;
        idle(3);
        issue(1'b0, 6'h08, 16'h0, 1'b0, EXP_RD);
        idle(3);

        // R8: a read request arriving during a write must be dropped
        begin
            exp_t e;
            shadow[6'h09] = 16'hA5C3;
            e.is_wr = 1'b1; e.a = 6'h09; e.d = 16'hA5C3; e.len = wr_idle;
            exp_q.push_back(e);
            req = 1'b1; we = 1'b1; addr = 6'h09; wdata = 16'hA5C3; oe_hold_mode = 1'b0;
            @(negedge clk);
            req = 1'b0;
            @(negedge clk);
            req = 1'b1; we = 1'b0; addr = 6'h05;
            @(negedge clk);
            req = 1'b0;
            wait_done();
            idle(8);
            check(exp_q.size() == 0, "R8 no extra access", exp_q.size(), 0);
            check(mem_ce_n && mem_oe_n, "R8 bus quiet after drop", {mem_ce_n, mem_oe_n}, 2'b11);
        end
        issue(1'b0, 6'h09, 16'h0, 1'b0, EXP_RD);
        issue(1'b0, 6'h05, 16'h0, 1'b0, EXP_RD);
        idle(4);
        finish_run();
    end

endmodule